// File: doc/BRIEF.md
# Descriptor Image Stream Validator

This block inspects a device descriptor image as it streams past, one byte per cycle in which `byte_valid` is high, beginning with header byte 0. In one pass it checks the integrity byte that guards the 64-bit identifier and captures the identifier, vendor and model fields. It also runs a CRC-32C over the data region and compares it with the stored value. Once the fixed header has gone by, it follows the chain of length-prefixed entries and raises a one-cycle strobe for each entry, carrying that entry's kind, index and disabled flag.

A frame begins with a `frame_start` pulse, which clears every result. The image bytes follow. `done` rises when the image has been consumed or when a fatal condition ends the frame early. All result flags hold their values until the next `frame_start`. Bytes that arrive before the first `frame_start`, or after `done`, are ignored. The block does not interpret entry payloads.

Top module: `desc_image_checker`

## Requirements
- R1: A `frame_start` pulse clears `done` and every flag and output in the cycle that follows. Byte 0 is the first byte accepted after the pulse. Bytes offered while no frame is open are ignored.
- R2: The header check runs a CRC-8 over bytes 1 to 8 (polynomial 0x07, start value 0xFF, most significant bit first, no output inversion) and compares the result with byte 0. On a match `hdr_crc_ok` is set. On a mismatch `hdr_crc_bad` and `done` are set one cycle after byte 8 is accepted, and the frame produces no entry strobes.
- R3: `ident` holds bytes 1 to 8 with byte 1 in bits 7:0. `vendor_id` is bytes 16 (low) and 17 (high). `model_id` is bytes 18 (low) and 19 (high).
- R4: The data length is the low 10 bits of the little-endian field formed by bytes 14 and 15. The upper 6 bits are ignored. The image size is that length plus 13. `done` rises one cycle after byte (size-1) is accepted, and later bytes change nothing.
- R5: The data check runs a reflected CRC-32C (polynomial 0x82F63B78, start value all ones, final inversion) over bytes 13 to size-1 and compares it with bytes 9 to 12, which are stored little-endian. The result sets `data_crc_ok`. A mismatch does not stop the entry walk.
- R6: An image size below 22 sets `size_err` and `done` one cycle after byte 15 is accepted, and the frame produces no entry strobes.
- R7: Entries start at byte 22. The first byte of an entry is its total length, including the two header bytes. In the second byte, bits 5:0 are the index, bit 6 is the disabled flag and bit 7 is the kind (1 = port, 0 = generic). `ent_stb` pulses for one cycle after the second byte is accepted, with `ent_port`, `ent_index` and `ent_disabled` valid in that cycle.
- R8: The walk sets `overrun_err` and stops in any of these cases: an entry starts on the last byte of the image, its length is 0 or 1, or its length runs past the end of the image. No strobes follow.
- R9: A port entry whose length is not 8 still strobes. It then sets `port_len_err`, and the walk stops.
- R10: `rev_warn` is set when byte 13 is greater than 2.
- R11: Every flag, once set, holds until the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Opens a new frame and clears the results |
| byte_valid | input | 1 | `byte_data` carries an image byte this cycle |
| byte_data | input | 8 | Image byte |
| done | output | 1 | Frame finished, either complete or ended by a fatal error |
| hdr_crc_ok | output | 1 | Header CRC-8 matched |
| hdr_crc_bad | output | 1 | Header CRC-8 mismatched (fatal) |
| data_crc_ok | output | 1 | Data-region CRC-32C matched |
| size_err | output | 1 | Image size below the header size |
| overrun_err | output | 1 | Entry chain broke the image bounds |
| port_len_err | output | 1 | Port entry length was not 8 |
| rev_warn | output | 1 | Revision byte greater than 2 |
| ident | output | 64 | Identifier, little-endian |
| vendor_id | output | 16 | Vendor identifier |
| model_id | output | 16 | Model identifier |
| ent_stb | output | 1 | One-cycle pulse for each decoded entry |
| ent_port | output | 1 | Kind of the strobed entry (1 = port) |
| ent_index | output | 6 | Index of the strobed entry |
| ent_disabled | output | 1 | Disabled flag of the strobed entry |

## Verification
The bench sweeps the length of a single generic entry from 2 to 40 bytes and sets junk in the upper bits of the length field. A design that failed to mask the length, or that was off by one at the image end, would then miss `done` or flag a false overrun. It also builds each bound case of the walk: an entry that starts on the last byte, lengths of zero and one, and a length that runs one entry past the end. A walker that compared against the wrong bound would strobe an entry that should have been rejected. The bench further checks that a header CRC failure, or a short image, stops the frame at the right byte and gives no strobes. It checks that a corrupted data CRC leaves the walk running, that revision 2 and revision 3 fall on either side of the warning, and that bytes sent after `done` leave every result unchanged.

// File: rtl/dimg_pkg.sv
package dimg_pkg;
    localparam int HDR_LEN      = 22;
    localparam int DATA_START   = 13;
    localparam int POS_CHK8     = 0;
    localparam int POS_ID_FIRST = 1;
    localparam int POS_ID_LAST  = 8;
    localparam int POS_SUM_LO   = 9;
    localparam int POS_SUM_HI   = 12;
    localparam int POS_REV      = 13;
    localparam int POS_LEN_LO   = 14;
    localparam int POS_LEN_HI   = 15;
    localparam int POS_VEND     = 16;
    localparam int POS_MODEL    = 18;
    localparam int PORT_ENT_LEN = 8;
    localparam int MAX_REV      = 2;

    localparam logic [7:0]  CRC8_POLY   = 8'h07;
    localparam logic [31:0] CRC32C_REFL = 32'h82F6_3B78;

    typedef enum logic {
        ENT_GENERIC = 1'b0,
        ENT_PORT    = 1'b1
    } ent_kind_e;
endpackage

// File: rtl/dimg_crc_step.sv
module dimg_crc_step #(
    parameter int           W       = 8,
    parameter logic [W-1:0] POLY    = '0,
    parameter bit           REFLECT = 1'b0
) (
    input  logic [W-1:0] crc_i,
    input  logic [7:0]   data_i,
    output logic [W-1:0] crc_o
);
    generate
        if (REFLECT) begin : g_lsb_first
            always_comb begin
                logic [W-1:0] c;
                c = crc_i ^ W'(data_i);
                for (int i = 0; i < 8; i++) begin
                    c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
                end
                crc_o = c;
            end
        end else begin : g_msb_first
            always_comb begin
                logic [W-1:0] c;
                c = crc_i ^ (W'(data_i) << (W - 8));
                for (int i = 0; i < 8; i++) begin
                    c = c[W-1] ? ((c << 1) ^ POLY) : (c << 1);
                end
                crc_o = c;
            end
        end
    endgenerate
endmodule

// File: rtl/dimg_entry_walker.sv
module dimg_entry_walker
    import dimg_pkg::*;
#(
    parameter int POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] total,
    input  logic [7:0]       data,
    output logic             ent_stb,
    output logic             ent_port,
    output logic [5:0]       ent_index,
    output logic             ent_disabled,
    output logic             overrun,
    output logic             port_err
);
    localparam logic [POS_W-1:0] P_FIRST = POS_W'(HDR_LEN);
    localparam logic [7:0]       L_PORT  = 8'(PORT_ENT_LEN);

    typedef struct packed {
        logic             in_attr;
        logic             stopped;
        logic [POS_W-1:0] next_start;
        logic [7:0]       len;
        logic             stb;
        logic             port;
        logic [5:0]       index;
        logic             dis;
        logic             overrun;
        logic             port_err;
    } walk_t;

    walk_t w_d, w_q;

    logic [POS_W:0] pos_ext, total_ext, pos_plus1, pos_plus_len;

    always_comb begin
        pos_ext      = {1'b0, pos};
        total_ext    = {1'b0, total};
        pos_plus1    = pos_ext + 1'b1;
        pos_plus_len = pos_ext + (POS_W + 1)'(data);

        w_d     = w_q;
        w_d.stb = 1'b0;
        if (clear) begin
            w_d            = '0;
            w_d.next_start = P_FIRST;
        end else if (step && !w_q.stopped) begin
            if (!w_q.in_attr) begin
                if (pos == w_q.next_start) begin
                    if (pos_plus1 == total_ext || data < 8'd2 || pos_plus_len > total_ext) begin
                        w_d.overrun = 1'b1;
                        w_d.stopped = 1'b1;
                    end else begin
                        w_d.len     = data;
                        w_d.in_attr = 1'b1;
                    end
                end
            end else begin
                w_d.stb        = 1'b1;
                w_d.port       = data[7];
                w_d.dis        = data[6];
                w_d.index      = data[5:0];
                w_d.in_attr    = 1'b0;
                w_d.next_start = w_q.next_start + POS_W'(w_q.len);
                if (ent_kind_e'(data[7]) == ENT_PORT && w_q.len != L_PORT) begin
                    w_d.port_err = 1'b1;
                    w_d.stopped  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign ent_stb      = w_q.stb;
    assign ent_port     = w_q.port;
    assign ent_index    = w_q.index;
    assign ent_disabled = w_q.dis;
    assign overrun      = w_q.overrun;
    assign port_err     = w_q.port_err;
endmodule

// File: rtl/desc_image_checker.sv
module desc_image_checker
    import dimg_pkg::*;
#(
    parameter int LEN_BITS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        done,
    output logic        hdr_crc_ok,
    output logic        hdr_crc_bad,
    output logic        data_crc_ok,
    output logic        size_err,
    output logic        overrun_err,
    output logic        port_len_err,
    output logic        rev_warn,
    output logic [63:0] ident,
    output logic [15:0] vendor_id,
    output logic [15:0] model_id,
    output logic        ent_stb,
    output logic        ent_port,
    output logic [5:0]  ent_index,
    output logic        ent_disabled
);
    localparam int POS_W = LEN_BITS + 1;
    localparam logic [POS_W-1:0] P_CHK8   = POS_W'(POS_CHK8);
    localparam logic [POS_W-1:0] P_ID_LO  = POS_W'(POS_ID_FIRST);
    localparam logic [POS_W-1:0] P_ID_HI  = POS_W'(POS_ID_LAST);
    localparam logic [POS_W-1:0] P_SUM_LO = POS_W'(POS_SUM_LO);
    localparam logic [POS_W-1:0] P_SUM_HI = POS_W'(POS_SUM_HI);
    localparam logic [POS_W-1:0] P_REV    = POS_W'(POS_REV);
    localparam logic [POS_W-1:0] P_LEN_LO = POS_W'(POS_LEN_LO);
    localparam logic [POS_W-1:0] P_LEN_HI = POS_W'(POS_LEN_HI);
    localparam logic [POS_W-1:0] P_VEND   = POS_W'(POS_VEND);
    localparam logic [POS_W-1:0] P_MODEL  = POS_W'(POS_MODEL);
    localparam logic [POS_W-1:0] P_DATA   = POS_W'(DATA_START);
    localparam logic [POS_W-1:0] P_HDR    = POS_W'(HDR_LEN);
    localparam logic [7:0]       REV_LIM  = 8'(MAX_REV);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] total;
        logic             total_known;
        logic [7:0]       crc8;
        logic [7:0]       exp8;
        logic [7:0]       len_lo;
        logic [31:0]      crc32;
        logic [31:0]      exp32;
        logic [63:0]      ident;
        logic [15:0]      vendor;
        logic [15:0]      model;
        logic             hdr_ok;
        logic             hdr_bad;
        logic             data_ok;
        logic             size_err;
        logic             rev_warn;
    } st_t;

    st_t s_d, s_q;

    logic             accept, in_data, walk_step;
    logic [7:0]       crc8_nx;
    logic [31:0]      crc32_nx;
    logic [15:0]      raw_len;
    logic [POS_W-1:0] total_nx;
    logic [5:0]       id_sel;
    logic [4:0]       sum_sel;

    dimg_crc_step #(.W(8), .POLY(CRC8_POLY), .REFLECT(1'b0)) u_crc8 (
        .crc_i (s_q.crc8), .data_i(byte_data), .crc_o(crc8_nx)
    );

    dimg_crc_step #(.W(32), .POLY(CRC32C_REFL), .REFLECT(1'b1)) u_crc32 (
        .crc_i (s_q.crc32), .data_i(byte_data), .crc_o(crc32_nx)
    );

    always_comb begin
        accept    = byte_valid && s_q.busy && !s_q.done && !frame_start;
        in_data   = (s_q.pos >= P_DATA) && (!s_q.total_known || s_q.pos < s_q.total);
        walk_step = accept && s_q.total_known && (s_q.pos >= P_HDR) && (s_q.pos < s_q.total);
        raw_len   = {byte_data, s_q.len_lo};
        total_nx  = POS_W'(raw_len[LEN_BITS-1:0]) + P_DATA;
        id_sel    = {s_q.pos[2:0] - 3'd1, 3'b000};
        sum_sel   = {s_q.pos[1:0] - 2'd1, 3'b000};

        s_d = s_q;
        if (frame_start) begin
            s_d       = '0;
            s_d.busy  = 1'b1;
            s_d.crc8  = 8'hFF;
            s_d.crc32 = '1;
        end else if (accept) begin
            s_d.pos = s_q.pos + 1'b1;
            if (s_q.pos == P_CHK8) s_d.exp8 = byte_data;
            if (s_q.pos >= P_ID_LO && s_q.pos <= P_ID_HI) begin
                s_d.crc8                = crc8_nx;
                s_d.ident[id_sel +: 8]  = byte_data;
            end
            if (s_q.pos == P_ID_HI) begin
                if (crc8_nx == s_q.exp8) begin
                    s_d.hdr_ok = 1'b1;
                end else begin
                    s_d.hdr_bad = 1'b1;
                    s_d.done    = 1'b1;
                end
            end
            if (s_q.pos >= P_SUM_LO && s_q.pos <= P_SUM_HI) s_d.exp32[sum_sel +: 8] = byte_data;
            if (s_q.pos == P_REV)    s_d.rev_warn = (byte_data > REV_LIM);
            if (s_q.pos == P_LEN_LO) s_d.len_lo   = byte_data;
            if (s_q.pos == P_LEN_HI) begin
                s_d.total       = total_nx;
                s_d.total_known = 1'b1;
                if (total_nx < P_HDR) begin
                    s_d.size_err = 1'b1;
                    s_d.done     = 1'b1;
                end
            end
            if (s_q.pos == P_VEND)          s_d.vendor[7:0]  = byte_data;
            if (s_q.pos == P_VEND + 1'b1)   s_d.vendor[15:8] = byte_data;
            if (s_q.pos == P_MODEL)         s_d.model[7:0]   = byte_data;
            if (s_q.pos == P_MODEL + 1'b1)  s_d.model[15:8]  = byte_data;
            if (in_data) begin
                s_d.crc32 = crc32_nx;
                if (s_q.total_known && s_q.pos == s_q.total - 1'b1) begin
                    s_d.done    = 1'b1;
                    s_d.data_ok = (~crc32_nx == s_q.exp32);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dimg_entry_walker #(.POS_W(POS_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (frame_start),
        .step        (walk_step),
        .pos         (s_q.pos),
        .total       (s_q.total),
        .data        (byte_data),
        .ent_stb     (ent_stb),
        .ent_port    (ent_port),
        .ent_index   (ent_index),
        .ent_disabled(ent_disabled),
        .overrun     (overrun_err),
        .port_err    (port_len_err)
    );

    assign done        = s_q.done;
    assign hdr_crc_ok  = s_q.hdr_ok;
    assign hdr_crc_bad = s_q.hdr_bad;
    assign data_crc_ok = s_q.data_ok;
    assign size_err    = s_q.size_err;
    assign rev_warn    = s_q.rev_warn;
    assign ident       = s_q.ident;
    assign vendor_id   = s_q.vendor;
    assign model_id    = s_q.model;
endmodule

// File: rtl/dimg_checker.sv
module dimg_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic done,
    input logic hdr_crc_ok,
    input logic hdr_crc_bad,
    input logic size_err,
    input logic overrun_err,
    input logic port_len_err,
    input logic ent_stb
);
    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !done && !hdr_crc_bad && !hdr_crc_ok && !size_err
                        && !overrun_err && !port_len_err && !ent_stb);

    a_r2_hdr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_crc_ok && hdr_crc_bad));

    a_r2_bad_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_crc_bad |-> done && !ent_stb);

    a_r6_short_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> done && !ent_stb);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ent_stb |=> !ent_stb);

    a_r8_quiet_after_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err && !frame_start |=> !ent_stb);

    a_r9_quiet_after_port_err: assert property (@(posedge clk) disable iff (!rst_n)
        port_len_err && !frame_start |=> !ent_stb);

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done && !frame_start |=> done);

    a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err && !frame_start |=> overrun_err);
endmodule

bind desc_image_checker dimg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .done        (done),
    .hdr_crc_ok  (hdr_crc_ok),
    .hdr_crc_bad (hdr_crc_bad),
    .size_err    (size_err),
    .overrun_err (overrun_err),
    .port_len_err(port_len_err),
    .ent_stb     (ent_stb)
);

// File: tb/desc_image_checker_tb.sv
module desc_image_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        done, hdr_crc_ok, hdr_crc_bad, data_crc_ok, size_err;
    logic        overrun_err, port_len_err, rev_warn;
    logic [63:0] ident;
    logic [15:0] vendor_id, model_id;
    logic        ent_stb, ent_port, ent_disabled;
    logic [5:0]  ent_index;

    always #2 clk = ~clk;

    desc_image_checker u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .done(done), .hdr_crc_ok(hdr_crc_ok), .hdr_crc_bad(hdr_crc_bad),
        .data_crc_ok(data_crc_ok), .size_err(size_err),
        .overrun_err(overrun_err), .port_len_err(port_len_err),
        .rev_warn(rev_warn), .ident(ident), .vendor_id(vendor_id),
        .model_id(model_id), .ent_stb(ent_stb), .ent_port(ent_port),
        .ent_index(ent_index), .ent_disabled(ent_disabled)
    );

    int nchk = 0;
    int nerr = 0;
    logic [7:0] img [0:127];

    int         stb_total = 0;
    logic [7:0] rec_attr [0:255];

    always @(negedge clk) begin
        if (ent_stb) begin
            rec_attr[stb_total % 256] = {ent_port, ent_disabled, ent_index};
            stb_total++;
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc8(int first, int n);
        logic [7:0] v = 8'hFF;
        for (int i = 0; i < n; i++) begin
            v ^= img[first + i];
            for (int j = 0; j < 8; j++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
        end
        return v;
    endfunction

    function automatic logic [31:0] ref_crc32c(int first, int n);
        logic [31:0] v = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            v ^= {24'd0, img[first + i]};
            for (int j = 0; j < 8; j++) v = v[0] ? ((v >> 1) ^ 32'h82F6_3B78) : (v >> 1);
        end
        return ~v;
    endfunction

    // header with a length field; hi6 lands in the ignored upper bits
    task automatic build(int total, logic [5:0] hi6, logic [7:0] rev);
        int dlen = total - 13;
        for (int i = 0; i < 128; i++) img[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 8; i++) img[1 + i] = 8'hA0 + 8'(i);
        img[13] = rev;
        img[14] = 8'(dlen);
        img[15] = {hi6, 2'(dlen >> 8)};
        img[16] = 8'h34; img[17] = 8'h12;
        img[18] = 8'h78; img[19] = 8'h56;
    endtask

    task automatic put_ent(inout int at, input int len, input logic [7:0] attr);
        img[at] = 8'(len);
        img[at + 1] = attr;
        at += len;
    endtask

    task automatic seal(int total);
        logic [31:0] c;
        img[0] = ref_crc8(1, 8);
        c = ref_crc32c(13, total - 13);
        img[9] = c[7:0]; img[10] = c[15:8]; img[11] = c[23:16]; img[12] = c[31:24];
    endtask

    task automatic send(int n, bit open, output int nstb);
        int base;
        if (open) begin
            @(negedge clk) frame_start = 1'b1;
            @(negedge clk) frame_start = 1'b0;
        end
        base = stb_total;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1;
            byte_data  = img[i];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        repeat (3) @(negedge clk);
        nstb = stb_total - base;
    endtask

    initial begin
        #(4 * 200000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int n;
        int at;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset flags", {hdr_crc_ok, hdr_crc_bad, data_crc_ok, size_err, overrun_err, port_len_err, rev_warn}, 0);

        // bytes with no open frame are ignored
        build(38, 6'd0, 8'd1); seal(38);
        send(38, 1'b0, n);
        chk("R1", "no frame done", done, 0);
        chk("R1", "no frame stb", n, 0);
        chk("R1", "no frame ident", ident, 0);

        // full good image: generic 5, port 8 disabled, generic 3
        build(38, 6'd0, 8'd1);
        at = 22;
        put_ent(at, 5, 8'h01);
        put_ent(at, 8, 8'hC5);
        put_ent(at, 3, 8'h02);
        seal(38);
        send(38, 1'b1, n);
        chk("R2", "hdr ok", {hdr_crc_ok, hdr_crc_bad}, 2'b10);
        chk("R3", "ident", ident, 64'hA7A6A5A4A3A2A1A0);
        chk("R3", "vendor", vendor_id, 16'h1234);
        chk("R3", "model", model_id, 16'h5678);
        chk("R4", "done at end", done, 1);
        chk("R5", "data crc ok", data_crc_ok, 1);
        chk("R7", "strobe count", n, 3);
        chk("R7", "entry0", rec_attr[(stb_total - 3) % 256], 8'h01);
        chk("R7", "entry1 port disabled idx5", rec_attr[(stb_total - 2) % 256], 8'hC5);
        chk("R7", "entry2", rec_attr[(stb_total - 1) % 256], 8'h02);
        chk("R8", "no overrun", {overrun_err, port_len_err, size_err}, 0);
        chk("R10", "rev 1 no warn", rev_warn, 0);

        // bytes after done change nothing
        send(20, 1'b0, n);
        chk("R4", "trailing stb", n, 0);
        chk("R4", "trailing flags", {done, hdr_crc_ok, data_crc_ok, overrun_err}, 4'b1110);

        // fresh frame clears
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        chk("R1", "cleared", {done, hdr_crc_ok, data_crc_ok, ident != 0}, 0);

        // corrupt data CRC: walk continues
        build(38, 6'd0, 8'd2);
        at = 22;
        put_ent(at, 5, 8'h01); put_ent(at, 8, 8'h85); put_ent(at, 3, 8'h02);
        seal(38);
        img[10] ^= 8'h40;
        send(38, 1'b1, n);
        chk("R5", "bad data crc", data_crc_ok, 0);
        chk("R5", "walk continues", n, 3);
        chk("R10", "rev 2 no warn", rev_warn, 0);

        // header CRC mismatch, ends after byte 8
        build(38, 6'd0, 8'd1);
        at = 22; put_ent(at, 16, 8'h04);
        seal(38);
        img[0] ^= 8'h01;
        send(9, 1'b1, n);
        chk("R2", "bad hdr done after byte 8", {done, hdr_crc_bad, hdr_crc_ok}, 3'b110);
        send(29, 1'b0, n);
        chk("R2", "bad hdr no strobes", n, 0);
        chk("R11", "bad hdr held", hdr_crc_bad, 1);

        // too short: size 18
        build(18, 6'd0, 8'd3);
        seal(18);
        send(16, 1'b1, n);
        chk("R6", "short done after byte 15", {done, size_err}, 2'b11);
        chk("R10", "rev 3 warn", rev_warn, 1);
        send(10, 1'b0, n);
        chk("R6", "short no strobes", n, 0);

        // zero length entry after one good entry
        build(30, 6'd0, 8'd1);
        at = 22; put_ent(at, 4, 8'h07);
        img[26] = 8'd0;
        seal(30);
        send(30, 1'b1, n);
        chk("R8", "zero len overrun", overrun_err, 1);
        chk("R8", "zero len strobes", n, 1);
        chk("R11", "done after overrun", done, 1);

        // length one
        build(30, 6'd0, 8'd1);
        img[22] = 8'd1;
        seal(30);
        send(30, 1'b1, n);
        chk("R8", "len one overrun", {overrun_err, n == 0}, 2'b11);

        // length runs past end
        build(28, 6'd0, 8'd1);
        img[22] = 8'd7; img[23] = 8'h03;
        seal(28);
        send(28, 1'b1, n);
        chk("R8", "past end overrun", {overrun_err, n == 0}, 2'b11);

        // entry starts on last byte
        build(26, 6'd0, 8'd1);
        at = 22; put_ent(at, 3, 8'h09);
        img[25] = 8'd2;
        seal(26);
        send(26, 1'b1, n);
        chk("R8", "last byte overrun", {overrun_err, n == 1}, 2'b11);

        // port entry of wrong length stops walk
        build(31, 6'd0, 8'd1);
        at = 22; put_ent(at, 6, 8'h83); put_ent(at, 3, 8'h01);
        seal(31);
        send(31, 1'b1, n);
        chk("R9", "port len err", {port_len_err, overrun_err}, 2'b10);
        chk("R9", "one strobe", n, 1);
        chk("R9", "strobed port idx3", rec_attr[(stb_total - 1) % 256], 8'h83);

        // sweep single generic entry length, junk in upper length bits
        for (int len = 2; len <= 40; len++) begin
            build(22 + len, 6'b101010, 8'd0);
            at = 22; put_ent(at, len, {2'b00, 6'(len)});
            seal(22 + len);
            send(22 + len, 1'b1, n);
            chk("R4", $sformatf("sweep len %0d flags", len),
                {done, data_crc_ok, overrun_err, size_err, port_len_err}, 5'b11000);
            chk("R7", $sformatf("sweep len %0d strobe", len),
                {n[7:0], rec_attr[(stb_total - 1) % 256]}, {8'd1, 2'b00, 6'(len)});
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule